// File: doc/BRIEF.md
# Exception Escalation and Classification Unit

This unit sits between the sources that raise processor exceptions and the logic that delivers them. Each raised exception arrives as a vector number and a 16-bit error code. The unit works out how that exception is delivered. It sorts the vector into an execution class and an escalation kind. It decides whether an error code goes on the stack. It tracks how deeply exceptions are nested, so that a second exception that cannot be handled on top of the first becomes a double fault. A nesting level that cannot be recovered becomes a shutdown pulse.

Each accepted exception produces one delivery record. The record holds the final vector, the push-error flag, the adjusted error code, a flag asking the core to roll back its instruction and stack pointers, a flag asking it to set the resume flag in the saved flags image, and a flag for vectors the unit does not recognise. When the delivery logic has completed a delivery, it pulses `deliver_done`. That pulse ends the nesting episode.

Exceptions enter on a valid/ready channel, and records leave on a valid/ready channel with one register stage. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the record is held unchanged and no new exception is taken. `deliver_done`, `in_real_mode` and `shutdown` are plain level/pulse signals. `in_real_mode` is sampled with the exception it accompanies.

Top module: `exc_escalation_unit`

## Requirements
- R1: An error code is pushed for vectors 8, 10, 11, 12, 13, 14 and 17. No other vector pushes one.
- R2: Execution class and its flags:
  - Vectors 1, 3 and 4 are traps. Vectors 8, 9 and 18 are aborts. All other vectors are faults.
  - `out_restore_ip` is set exactly for faults.
  - `out_set_rf` is set for faults whose final vector is not 1.
- R3: Escalation kinds:
  - Vectors 0 and 9 to 13 are contributory. Vector 14 is the page-fault kind. Vector 8 is the double-fault kind. Every other vector is benign.
  - When judged as a second exception, a raised vector 8 counts as contributory.
- R4: A second exception is escalated in two cases: when it is contributory after a contributory first, and when it is contributory or page-fault after a page-fault first. After a benign first, every second exception is allowed.
- R5: An escalated exception is delivered as vector 8, class abort, with a pushed error code. A vector 8 delivery always carries error code bits [15:1] equal to zero.
- R6: Shutdown conditions:
  - An exception accepted at nesting level 2 causes shutdown. So does one accepted at level 1 when the first recorded exception was of the double-fault kind.
  - Shutdown raises `shutdown` for exactly one cycle and delivers no record.
  - Shutdown clears the nesting state.
- R7: The external-event flag:
  - For every kind except page fault, bit 0 of the delivered error code equals the external-event flag. Page-fault codes pass through unchanged.
  - The flag becomes 1 after any accepted exception.
- R8: `deliver_done` clears the nesting level and the external-event flag. An exception accepted in the same cycle is judged against the cleared state.
- R9: Vectors 15 and 19 to 31 raise `out_illegal`. They are handled as benign faults with no error code.
- R10: When `in_real_mode` is high for an exception, `out_push_err` is 0 for its record.
- R11: Back-pressure:
  - `in_ready` equals `!out_valid || out_ready`.
  - A stalled record stays unchanged.
  - An exception offered while `in_ready` is low is not taken and leaves the nesting state untouched.
  - Without acceptance, a drained slot reads `out_valid` = 0.
- R12: After reset, `out_valid` and `shutdown` are 0, `in_ready` is 1, the nesting level is 0 and the external-event flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raised exception present |
| in_ready | output | 1 | Unit can accept an exception this cycle |
| in_vector | input | VEC_W | Raised vector number |
| in_err_code | input | ERR_W | Error code offered with the exception |
| in_real_mode | input | 1 | Exception raised while in real-address mode |
| deliver_done | input | 1 | Pulse: the current delivery completed, end of nesting episode |
| out_valid | output | 1 | Delivery record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_vector | output | VEC_W | Final vector to deliver |
| out_push_err | output | 1 | Push the error code |
| out_err_code | output | ERR_W | Adjusted error code |
| out_restore_ip | output | 1 | Roll back instruction and stack pointers |
| out_set_rf | output | 1 | Set the resume flag in the saved flags image |
| out_illegal | output | 1 | Raised vector is not a defined exception |
| shutdown | output | 1 | One-cycle pulse: unrecoverable nesting |

## Verification
The nesting level, the first recorded kind and the external-event flag are hidden state. A corrupted value only shows up on the next exception. Such a value appears as a vector 8 where the raw vector was expected (or the reverse), as a shutdown pulse one exception too early or too late, or as a wrong bit 0 in the delivered code. Every ordered pair of vectors is therefore followed by a third exception, so that a wrong level shows at the ports within two acceptances. A stall window with an offered but refused exception shows whether that exception leaked into the nesting state: the following exception has to escalate rather than shut down.

// File: rtl/exc_esc_pkg.sv
package exc_esc_pkg;

  typedef enum logic [1:0] {
    ET_BENIGN  = 2'd0,
    ET_CONTRIB = 2'd1,
    ET_PAGE    = 2'd2,
    ET_DOUBLE  = 2'd3
  } exc_kind_e;

  typedef enum logic [1:0] {
    EC_TRAP  = 2'd0,
    EC_FAULT = 2'd1,
    EC_ABORT = 2'd2
  } exc_class_e;

  typedef struct packed {
    exc_kind_e  kind;
    exc_class_e cls;
    logic       has_err;
    logic       illegal;
  } exc_attr_t;

  localparam int unsigned VEC_DOUBLE = 8;
  localparam int unsigned VEC_DEBUG  = 1;

  // Static attributes of one vector number.
  function automatic exc_attr_t attr_of(input int unsigned v);
    exc_attr_t a;
    a.kind    = ET_BENIGN;
    a.cls     = EC_FAULT;
    a.has_err = 1'b0;
    a.illegal = (v == 15) || (v >= 19);
    case (v)
      0, 9, 10, 11, 12, 13: a.kind = ET_CONTRIB;
      14:                   a.kind = ET_PAGE;
      8:                    a.kind = ET_DOUBLE;
      default:              a.kind = ET_BENIGN;
    endcase
    case (v)
      8, 10, 11, 12, 13, 14, 17: a.has_err = 1'b1;
      default:                   a.has_err = 1'b0;
    endcase
    case (v)
      1, 3, 4:  a.cls = EC_TRAP;
      8, 9, 18: a.cls = EC_ABORT;
      default:  a.cls = EC_FAULT;
    endcase
    return a;
  endfunction

  // May a second exception of kind 'second' be stacked on 'first'?
  function automatic logic second_ok(input exc_kind_e first, input exc_kind_e second);
    exc_kind_e s;
    s = (second == ET_DOUBLE) ? ET_CONTRIB : second;
    case (first)
      ET_BENIGN:  return 1'b1;
      ET_CONTRIB: return s != ET_CONTRIB;
      ET_PAGE:    return s == ET_BENIGN;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_esc_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic [VEC_W-1:0] vec_i,
  output exc_attr_t        attr_o
);
  localparam int NUM_VEC = 1 << VEC_W;

  exc_attr_t rom [NUM_VEC];

  generate
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_rom
      assign rom[i] = attr_of(i);
    end
  endgenerate

  assign attr_o = rom[vec_i];
endmodule

// File: rtl/exc_nest_track.sv
module exc_nest_track
  import exc_esc_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             done_i,
  input  logic             shutdown_i,
  input  exc_kind_e        kind_i,
  output logic [LVL_W-1:0] lvl_o,
  output exc_kind_e        first_o,
  output logic             ext_o
);
  logic [LVL_W-1:0] lvl_q;
  exc_kind_e        first_q;
  logic             ext_q;

  // A completion in the same cycle is seen before the new exception.
  assign lvl_o   = done_i ? '0 : lvl_q;
  assign first_o = done_i ? ET_BENIGN : first_q;
  assign ext_o   = done_i ? 1'b0 : ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      first_q <= ET_BENIGN;
      ext_q   <= 1'b0;
    end else if (accept_i && shutdown_i) begin
      lvl_q   <= '0;
      first_q <= ET_BENIGN;
      ext_q   <= 1'b0;
    end else if (accept_i) begin
      lvl_q <= lvl_o + LVL_W'(1);
      ext_q <= 1'b1;
      if (lvl_o == '0) first_q <= kind_i;
    end else if (done_i) begin
      lvl_q   <= '0;
      first_q <= ET_BENIGN;
      ext_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_esc_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int ERR_W = 16,
  parameter int LVL_W = 2
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             real_i,
  input  exc_attr_t        attr_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  exc_kind_e        first_i,
  input  logic             ext_i,
  output logic             shutdown_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             push_o,
  output logic [ERR_W-1:0] err_o,
  output logic             restore_o,
  output logic             set_rf_o,
  output logic             illegal_o,
  output exc_kind_e        kind_o
);
  logic             is_second;
  logic             escalate;
  exc_class_e       cls;
  logic [ERR_W-1:0] code_base;

  assign is_second  = (lvl_i == LVL_W'(1));
  assign shutdown_o = (lvl_i >= LVL_W'(2)) || (is_second && first_i == ET_DOUBLE);
  assign escalate   = is_second && !second_ok(first_i, attr_i.kind);

  assign vec_o  = escalate ? VEC_W'(VEC_DOUBLE) : vec_i;
  assign kind_o = escalate ? ET_DOUBLE : attr_i.kind;
  assign cls    = escalate ? EC_ABORT : attr_i.cls;
  assign push_o = (escalate || attr_i.has_err) && !real_i;

  assign code_base = (kind_o == ET_DOUBLE) ? '0 : err_i;
  assign err_o     = (kind_o == ET_PAGE) ? code_base : {code_base[ERR_W-1:1], ext_i};

  assign restore_o = (cls == EC_FAULT);
  assign set_rf_o  = restore_o && (vec_o != VEC_W'(VEC_DEBUG));
  assign illegal_o = attr_i.illegal && !escalate;
endmodule

// File: rtl/exc_escalation_unit.sv
module exc_escalation_unit
  import exc_esc_pkg::*;
#(
  parameter int VEC_W = 5,
  parameter int ERR_W = 16,
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_vector,
  input  logic [ERR_W-1:0] in_err_code,
  input  logic             in_real_mode,
  input  logic             deliver_done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vector,
  output logic             out_push_err,
  output logic [ERR_W-1:0] out_err_code,
  output logic             out_restore_ip,
  output logic             out_set_rf,
  output logic             out_illegal,
  output logic             shutdown
);
  exc_attr_t        attr;
  logic [LVL_W-1:0] lvl;
  exc_kind_e        first_kind;
  exc_kind_e        final_kind;
  logic             ext_flag;
  logic             accept;
  logic             esc_shutdown;
  logic [VEC_W-1:0] esc_vec;
  logic             esc_push;
  logic [ERR_W-1:0] esc_err;
  logic             esc_restore;
  logic             esc_rf;
  logic             esc_illegal;

  logic             out_valid_q;
  logic             shutdown_q;

  assign in_ready = !out_valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  exc_classify #(.VEC_W(VEC_W)) u_classify (
    .vec_i  (in_vector),
    .attr_o (attr)
  );

  exc_nest_track #(.LVL_W(LVL_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .done_i     (deliver_done),
    .shutdown_i (esc_shutdown),
    .kind_i     (final_kind),
    .lvl_o      (lvl),
    .first_o    (first_kind),
    .ext_o      (ext_flag)
  );

  exc_escalate #(.VEC_W(VEC_W), .ERR_W(ERR_W), .LVL_W(LVL_W)) u_escalate (
    .vec_i      (in_vector),
    .err_i      (in_err_code),
    .real_i     (in_real_mode),
    .attr_i     (attr),
    .lvl_i      (lvl),
    .first_i    (first_kind),
    .ext_i      (ext_flag),
    .shutdown_o (esc_shutdown),
    .vec_o      (esc_vec),
    .push_o     (esc_push),
    .err_o      (esc_err),
    .restore_o  (esc_restore),
    .set_rf_o   (esc_rf),
    .illegal_o  (esc_illegal),
    .kind_o     (final_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q    <= 1'b0;
      shutdown_q     <= 1'b0;
      out_vector     <= '0;
      out_push_err   <= 1'b0;
      out_err_code   <= '0;
      out_restore_ip <= 1'b0;
      out_set_rf     <= 1'b0;
      out_illegal    <= 1'b0;
    end else begin
      shutdown_q <= accept && esc_shutdown;
      if (accept && !esc_shutdown) begin
        out_valid_q    <= 1'b1;
        out_vector     <= esc_vec;
        out_push_err   <= esc_push;
        out_err_code   <= esc_err;
        out_restore_ip <= esc_restore;
        out_set_rf     <= esc_rf;
        out_illegal    <= esc_illegal;
      end else if (accept || out_ready) begin
        out_valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign shutdown  = shutdown_q;
endmodule

// File: rtl/exc_escalation_chk.sv
module exc_escalation_chk #(
  parameter int VEC_W = 5,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_real_mode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vector,
  input logic             out_push_err,
  input logic [ERR_W-1:0] out_err_code,
  input logic             out_restore_ip,
  input logic             out_set_rf,
  input logic             out_illegal,
  input logic             shutdown
);
  p_rf_needs_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_set_rf) |-> (out_restore_ip && out_vector != VEC_W'(1)));

  p_double_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_vector == VEC_W'(8)) |-> (out_err_code[ERR_W-1:1] == '0 && !out_restore_ip));

  p_shutdown_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !shutdown);

  p_shutdown_no_record_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !out_valid);

  p_illegal_benign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_push_err && out_restore_ip));

  p_real_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_real_mode) |=> !out_push_err);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vector) && $stable(out_err_code)
                                   && $stable(out_push_err)));

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && out_ready) |=> (!out_valid && !shutdown));
endmodule

bind exc_escalation_unit exc_escalation_chk #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_real_mode   (in_real_mode),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_vector     (out_vector),
  .out_push_err   (out_push_err),
  .out_err_code   (out_err_code),
  .out_restore_ip (out_restore_ip),
  .out_set_rf     (out_set_rf),
  .out_illegal    (out_illegal),
  .shutdown       (shutdown)
);

// File: tb/sim_exc_escalation_unit.sv
`timescale 1ns/1ps
module sim_exc_escalation_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_vector = '0;
  logic [15:0] in_err_code = '0;
  logic        in_real_mode = 1'b0;
  logic        deliver_done = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_vector;
  logic        out_push_err;
  logic [15:0] out_err_code;
  logic        out_restore_ip;
  logic        out_set_rf;
  logic        out_illegal;
  logic        shutdown;

  int checks = 0;
  int fails = 0;
  bit reported = 0;

  // reference state
  int m_lvl = 0;
  int m_first = 0;
  bit m_ext = 0;

  always #4 clk = ~clk;

  exc_escalation_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vector(in_vector), .in_err_code(in_err_code), .in_real_mode(in_real_mode),
    .deliver_done(deliver_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_vector(out_vector), .out_push_err(out_push_err), .out_err_code(out_err_code),
    .out_restore_ip(out_restore_ip), .out_set_rf(out_set_rf), .out_illegal(out_illegal),
    .shutdown(shutdown)
  );

  // kinds: 0 benign, 1 contributory, 2 page fault, 3 double fault
  function automatic int m_kind(int v);
    if (v == 14) return 2;
    if (v == 8) return 3;
    if (v == 0 || (v >= 9 && v <= 13)) return 1;
    return 0;
  endfunction

  function automatic bit m_push(int v);
    return (v == 8) || (v == 17) || (v >= 10 && v <= 14);
  endfunction

  // classes: 0 trap, 1 fault, 2 abort
  function automatic int m_cls(int v);
    if (v == 1 || v == 3 || v == 4) return 0;
    if (v == 8 || v == 9 || v == 18) return 2;
    return 1;
  endfunction

  function automatic bit m_ok(int f, int s);
    int s2 = (s == 3) ? 1 : s;
    if (f == 0) return 1;
    if (f == 1) return s2 != 1;
    if (f == 2) return s2 == 0;
    return 0;
  endfunction

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
  endtask

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Observed record: {valid, shutdown, vector, push, code, restore, rf, illegal}
  function automatic logic [63:0] observed(bit full);
    if (!full) return {62'd0, out_valid, shutdown};
    return {37'd0, out_valid, shutdown, out_vector, out_push_err, out_err_code,
            out_restore_ip, out_set_rf, out_illegal};
  endfunction

  task automatic pulse_done();
    @(negedge clk);
    deliver_done = 1'b1;
    @(negedge clk);
    deliver_done = 1'b0;
    m_lvl = 0; m_first = 0; m_ext = 0;
  endtask

  task automatic raise(int v, logic [15:0] code, bit real_m, bit dn, string tag);
    int   lvl_e = dn ? 0 : m_lvl;
    int   first_e = dn ? 0 : m_first;
    bit   ext_e = dn ? 1'b0 : m_ext;
    bit   shut;
    int   fv, k, c;
    logic [15:0] ec;
    bit   push, rst_ip, rf, ill;
    logic [63:0] exp;
    shut = (lvl_e >= 2) || (lvl_e == 1 && first_e == 3);
    fv = v; k = m_kind(v); ec = code;
    if (lvl_e == 1 && !m_ok(first_e, k)) begin
      fv = 8; k = 3;
    end
    if (k == 3) ec = 16'h0000;
    if (k != 2) ec[0] = ext_e;
    c = (fv != v) ? 2 : m_cls(fv);
    push = m_push(fv) && !real_m;
    rst_ip = (c == 1);
    rf = rst_ip && (fv != 1);
    ill = (v == 15) || (v >= 19);
    @(negedge clk);
    in_valid = 1'b1; in_vector = v[4:0]; in_err_code = code;
    in_real_mode = real_m; deliver_done = dn;
    @(posedge clk);
    #1;
    if (shut) begin
      check(tag, observed(0), {62'd0, 1'b0, 1'b1});
      m_lvl = 0; m_first = 0; m_ext = 0;
    end else begin
      exp = {37'd0, 1'b1, 1'b0, fv[4:0], push, ec, rst_ip, rf, ill};
      check(tag, observed(1), exp);
      m_lvl = lvl_e + 1; m_ext = 1;
      if (lvl_e == 0) m_first = k;
    end
    @(negedge clk);
    in_valid = 1'b0; deliver_done = 1'b0; in_real_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12 reset", {61'd0, out_valid, shutdown, in_ready}, {61'd0, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R12 after release", {61'd0, out_valid, shutdown, in_ready}, {61'd0, 1'b0, 1'b0, 1'b1});

    // R7: flag clear after reset, bit0 forced to 0; then set for the next one
    raise(13, 16'h1235, 0, 0, "R7 ext clear at first");
    raise(14, 16'h4440, 0, 0, "R7 page code passes");
    pulse_done();

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: every ordered pair, then a third exception
    for (int v1 = 0; v1 < 32; v1++) begin
      for (int v2 = 0; v2 < 32; v2++) begin
        bit odd = ((v1 + v2) % 2) == 1;
        logic [15:0] c1 = 16'h5A00 ^ 16'(v1 << 3) ^ {15'd0, odd};
        logic [15:0] c2 = 16'hC3C0 ^ 16'(v2 << 5) ^ {15'd0, ~odd};
        if (!odd) pulse_done();
        raise(v1, c1, 0, odd, odd ? "R8 done with first R1 R2 R9" : "R1 R2 R3 R9 first");
        raise(v2, c2, 0, 0, "R4 R5 R7 second");
        raise((v1 + v2) % 20, 16'h0F0F, 0, 0, "R6 third");
      end
    end

    // R10: real mode never pushes
    for (int v = 0; v < 32; v++) begin
      raise(v, 16'hFFFF, 1, 1, "R10 real mode");
    end

    // R11: stall, refused offer, then escalation proves level untouched
    pulse_done();
    out_ready = 1'b0;
    raise(13, 16'h2000, 0, 0, "R11 stall accept");
    @(negedge clk);
    check("R11 ready low", {63'd0, in_ready}, 64'd0);
    in_valid = 1'b1; in_vector = 5'd5; in_err_code = 16'h1111;
    @(posedge clk);
    #1;
    check("R11 held", {47'd0, out_valid, out_vector, out_err_code[10:0]},
          {47'd0, 1'b1, 5'd13, 11'h000});
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R11 drained", {63'd0, out_valid}, 64'd0);
    raise(13, 16'h2002, 0, 0, "R11 refused offer left level R4");
    raise(3, 16'h0000, 0, 0, "R6 shutdown after stall");

    // R6: vector 8 as first, then any second causes shutdown
    pulse_done();
    raise(8, 16'hBEEF, 0, 0, "R5 direct double zero code");
    raise(3, 16'h0000, 0, 0, "R6 second after double");
    raise(3, 16'h0006, 0, 0, "R6 state cleared by shutdown");

    report();
    $finish;
  end
endmodule